// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front end for an external asynchronous static RAM of 128K words by 16 bits. A client hands it one access at a time over a valid/ready handshake. Each access carries a 17-bit word address, a read/write flag, 16 bits of write data and two byte-lane enables. The controller turns the access into a timed sequence on the memory pins. Those pins are the address, an active-low chip select, an output enable, a write enable, two byte-lane strobes (low lane on data bits 7..0, high lane on bits 15..8) and a shared tri-state data bus. The block owns the bus only while it writes.

The read strobe time, the write pulse length and the idle gap after every access are parameters counted in clock cycles. A write first opens a setup cycle, then drops write enable for the pulse, then holds address, lanes and data for one closing cycle. A read holds chip select and output enable low and samples the bus on its final cycle. It returns the word one cycle later with a single-cycle valid pulse, and disabled lanes are forced to zero. After any access comes a gap in which the chip is deselected and the bus is free. This gap lets the memory and the controller hand the bus over without fighting.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, memCeN, memOeN, memWeN, memUbN and memLbN are all 1, the controller does not drive memData, and reqReady is 1.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady is then 0 for WR_CYCLES+2+TURN_CYCLES cycles after a write, and for RD_CYCLES+TURN_CYCLES cycles after a read.
- R3: A write runs in three phases. First comes one setup cycle with memCeN low and memWeN high. Next, memWeN is low for exactly WR_CYCLES cycles. Last comes one closing cycle with memWeN high while memCeN stays low. memAddr and the lane strobes stay unchanged from setup through the closing cycle.
- R4: reqLane bit 0 enables the low lane. It drives memLbN low and covers data bits 7..0. reqLane bit 1 enables the high lane. It drives memUbN low and covers bits 15..8. A write changes only the enabled lanes of the stored word.
- R5: A write with reqLane = 0 leaves the stored word unchanged.
- R6: A read holds memCeN and memOeN low and memWeN high for exactly RD_CYCLES cycles.
- R7: Read data appears on rspData with rspValid high for exactly one cycle, the cycle after the last read cycle. Bits of lanes not enabled in the request read as 0.
- R8: memOeN stays high while memWeN is low. The controller never drives memData while memOeN is low. It stops driving at least one full cycle before memOeN falls.
- R9: memAddr shows the requested address from the first cycle of the access.
- R10: Every access ends with TURN_CYCLES cycles in which all memory strobes are high and the bus is released, before reqReady returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqLane | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rspValid | output | 1 | One-cycle read data valid pulse |
| rspData | output | 16 | Read data, disabled lanes zero |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | High byte lane strobe, active low |
| memLbN | output | 1 | Low byte lane strobe, active low |
| memData | inout | 16 | Bidirectional memory data bus |

## Verification
Stimulus mixes random accesses with directed ones. The random accesses spread over sixteen addresses, each with a distinct upper address field, so words are rewritten and read back often. The directed accesses cover full-word, low-only, high-only and no-lane writes and reads. Partial writes followed by full reads show whether the lanes are mapped correctly and whether untouched bytes survive. Partial reads show whether the masking is right. Back-to-back write/read pairs test the phase lengths and the bus hand-over. The cycles of each phase are counted on the pins and compared with the parameter values. A shadow copy of memory in the bench supplies the expected read data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WEND,
    ST_TURN
  } ctlState_e;

  // strobes from control to datapath; pin strobes describe the NEXT cycle
  typedef struct packed {
    logic accept;   // capture request this edge
    logic selOn;    // chip selected next cycle
    logic oeOn;     // output enable next cycle
    logic weOn;     // write pulse next cycle
    logic laneOn;   // byte strobes follow lane mask next cycle
    logic driveOn;  // controller owns data bus next cycle
    logic sample;   // capture read bus this edge
  } ctlStrobe_t;

endpackage

// File: rtl/sram_lane_ctrl_fsm.sv
module sram_lane_ctrl_fsm
  import sram_lane_pkg::*;
#(
  parameter int RD_CYCLES   = 2,
  parameter int WR_CYCLES   = 1,
  parameter int TURN_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  localparam int MAX_A   = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
  localparam int MAX_CNT = (MAX_A > TURN_CYCLES) ? MAX_A : TURN_CYCLES;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

  ctlState_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic phaseDone;

  always_comb begin
    nextState = state;
    phaseDone = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = reqWrite ? ST_WSETUP : ST_READ;
      ST_READ: begin
        phaseDone = (cnt == RD_LAST);
        if (phaseDone) nextState = ST_TURN;
      end
      ST_WSETUP: nextState = ST_WPULSE;
      ST_WPULSE: begin
        phaseDone = (cnt == WR_LAST);
        if (phaseDone) nextState = ST_WEND;
      end
      ST_WEND: nextState = ST_TURN;
      ST_TURN: begin
        phaseDone = (cnt == TURN_LAST);
        if (phaseDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    nextCnt = (nextState != state) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.accept  = (state == ST_IDLE) && reqValid;
    strobe.selOn   = (nextState == ST_READ) || (nextState == ST_WSETUP) ||
                     (nextState == ST_WPULSE) || (nextState == ST_WEND);
    strobe.oeOn    = (nextState == ST_READ);
    strobe.weOn    = (nextState == ST_WPULSE);
    strobe.laneOn  = strobe.selOn;
    strobe.driveOn = (nextState == ST_WSETUP) || (nextState == ST_WPULSE) ||
                     (nextState == ST_WEND);
    strobe.sample  = (state == ST_READ) && (cnt == RD_LAST);
  end

endmodule

// File: rtl/sram_lane_ctrl_dp.sv
module sram_lane_ctrl_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqLane,
  input  logic [DATA_W-1:0]   memDataIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memByteN,
  output logic                drvEn,
  output logic [DATA_W-1:0]   wdataOut,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  laneReg, laneSel;
  logic [DATA_W-1:0] readMasked;

  assign laneSel = strobe.accept ? reqLane : laneReg;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign readMasked[i*8 +: 8] = laneReg[i] ? memDataIn[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      wdataOut <= '0;
      laneReg  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memByteN <= '1;
      drvEn    <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.accept) begin
        memAddr  <= reqAddr;
        wdataOut <= reqWdata;
        laneReg  <= reqLane;
      end
      memCeN   <= ~strobe.selOn;
      memOeN   <= ~strobe.oeOn;
      memWeN   <= ~strobe.weOn;
      memByteN <= ~({LANES{strobe.laneOn}} & laneSel);
      drvEn    <= strobe.driveOn;
      rspValid <= strobe.sample;
      if (strobe.sample) rspData <= readMasked;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter int RD_CYCLES   = 2,
  parameter int WR_CYCLES   = 1,
  parameter int TURN_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqLane,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  inout  wire  [DATA_W-1:0] memData
);

  ctlStrobe_t        strobe;
  logic [1:0]        memByteN;
  logic              drvEn;
  logic [DATA_W-1:0] wdataOut;

  sram_lane_ctrl_fsm #(
    .RD_CYCLES  (RD_CYCLES),
    .WR_CYCLES  (WR_CYCLES),
    .TURN_CYCLES(TURN_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_lane_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqLane  (reqLane),
    .memDataIn(memData),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memByteN (memByteN),
    .drvEn    (drvEn),
    .wdataOut (wdataOut),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  assign memUbN  = memByteN[1];
  assign memLbN  = memByteN[0];
  assign memData = drvEn ? wdataOut : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              drvEn
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memOeN && memWeN && memUbN && memLbN && !drvEn));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  pulse_inside_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && drvEn));

  // R3
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> ($stable(memAddr) && $stable(memUbN) && $stable(memLbN)));

  // R3
  write_close_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && $stable(memAddr) && $stable(memUbN) &&
                       $stable(memLbN) && drvEn));

  // R8
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !drvEn);

  // R8
  release_before_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> !$past(drvEn));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6
  read_write_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memUbN  (memUbN),
  .memLbN  (memLbN),
  .memAddr (memAddr),
  .drvEn   (drvEn)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int RD_C   = 2;
  localparam int WR_C   = 1;
  localparam int TURN_C = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqLane = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic [16:0] memAddr;
  logic        memCeN, memOeN, memWeN, memUbN, memLbN;
  wire  [15:0] memData;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  logic [15:0] model  [256];
  logic [15:0] expMem [256];

  always #10 clk = ~clk;  // 50 MHz

  sram_lane_ctrl #(
    .RD_CYCLES(RD_C), .WR_CYCLES(WR_C), .TURN_CYCLES(TURN_C)
  ) u_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLane(reqLane), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN), .memData(memData)
  );

  // asynchronous memory model, keyed by low address byte
  assign memData[7:0]  = (!memCeN && !memOeN && memWeN && !memLbN) ?
                         model[memAddr[7:0]][7:0]  : 8'bz;
  assign memData[15:8] = (!memCeN && !memOeN && memWeN && !memUbN) ?
                         model[memAddr[7:0]][15:8] : 8'bz;

  always @(negedge clk) begin
    if (rstN && !memCeN && !memWeN) begin
      if (!memLbN) model[memAddr[7:0]][7:0]  <= memData[7:0];
      if (!memUbN) model[memAddr[7:0]][15:8] <= memData[15:8];
    end
  end

  function automatic logic [15:0] laneMask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  function automatic logic [15:0] mergeWord(input logic [15:0] old,
      input logic [15:0] d, input logic [1:0] ln);
    return (old & ~laneMask(ln)) | (d & laneMask(ln));
  endfunction

  function automatic logic [16:0] addrOf(input int idx);
    logic [8:0] tag = 9'(idx * 37 + 5);
    return {tag, 8'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(reqReady == 1'b1, req, "ready when idle", int'(reqReady), 1);
    chk({memCeN, memOeN, memWeN, memUbN, memLbN} == 5'b11111, req,
        "strobes high when idle",
        int'({memCeN, memOeN, memWeN, memUbN, memLbN}), 5'h1f);
  endtask

  task automatic doAccess(input bit wr, input int idx, input logic [15:0] d,
                          input logic [1:0] ln);
    logic [16:0] a = addrOf(idx);
    int busy = 0;
    int weLow = 0;
    int oeLow = 0;
    int nValid = 0;
    int rspAt = -1;
    logic [15:0] got = '0;
    logic [15:0] expWord;
    @(negedge clk);
    chk(reqReady == 1'b1, "R2", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqLane = ln;
    @(negedge clk);
    reqValid = 1'b0;
    // first access cycle
    chk(memAddr == a, "R9", "address on pins", int'(memAddr), int'(a));
    chk({memUbN, memLbN} == ~ln, "R4", "lane strobes", int'({memUbN, memLbN}),
        int'(~ln));
    chk(memCeN == 1'b0, "R3", "chip selected", int'(memCeN), 0);
    if (wr) chk(memWeN == 1'b1, "R3", "setup cycle we high", int'(memWeN), 1);
    while (!reqReady && busy < 50) begin
      if (!memWeN) begin
        weLow++;
        chk(memOeN == 1'b1, "R8", "oe high in write pulse", int'(memOeN), 1);
        chk(memAddr == a, "R3", "address held in pulse", int'(memAddr), int'(a));
      end
      if (!memOeN) oeLow++;
      if (busy == (wr ? WR_C + 2 : RD_C))
        chk({memCeN, memOeN, memWeN, memUbN, memLbN} == 5'b11111, "R10",
            "turnaround deselected",
            int'({memCeN, memOeN, memWeN, memUbN, memLbN}), 5'h1f);
      if (rspValid) begin
        nValid++;
        if (rspAt < 0) rspAt = busy;
        got = rspData;
      end
      busy++;
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == WR_C + 2 + TURN_C, "R2", "write busy cycles", busy,
          WR_C + 2 + TURN_C);
      chk(weLow == WR_C, "R3", "write pulse cycles", weLow, WR_C);
      chk(oeLow == 0, "R8", "oe during write", oeLow, 0);
      chk(nValid == 0, "R7", "no response on write", nValid, 0);
      expMem[a[7:0]] = mergeWord(expMem[a[7:0]], d, ln);
    end else begin
      expWord = expMem[a[7:0]] & laneMask(ln);
      chk(busy == RD_C + TURN_C, "R2", "read busy cycles", busy, RD_C + TURN_C);
      chk(oeLow == RD_C, "R6", "read strobe cycles", oeLow, RD_C);
      chk(weLow == 0, "R6", "we high in read", weLow, 0);
      chk(nValid == 1, "R7", "valid pulse count", nValid, 1);
      chk(rspAt == RD_C, "R7", "valid pulse timing", rspAt, RD_C);
      chk(got == expWord, "R7", "read data", int'(got), int'(expWord));
    end
    checkIdle("R1");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    for (int i = 0; i < 256; i++) begin
      model[i]  = '0;
      expMem[i] = '0;
    end
    seedVal = $urandom(32'h5eed_1011);
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // directed lane corners
    doAccess(1'b1, 1, 16'hA5C3, 2'b11);
    doAccess(1'b0, 1, 16'h0000, 2'b11);
    doAccess(1'b1, 1, 16'h1177, 2'b01);   // R4 low lane only
    doAccess(1'b0, 1, 16'h0000, 2'b11);
    doAccess(1'b1, 1, 16'h9922, 2'b10);   // R4 high lane only
    doAccess(1'b0, 1, 16'h0000, 2'b01);
    doAccess(1'b0, 1, 16'h0000, 2'b10);
    doAccess(1'b1, 1, 16'hFFFF, 2'b00);   // R5 no lane write
    doAccess(1'b0, 1, 16'h0000, 2'b11);   // R5 word unchanged
    doAccess(1'b0, 1, 16'h0000, 2'b00);   // R7 masked to zero
    doAccess(1'b1, 2, 16'h3C3C, 2'b11);
    doAccess(1'b0, 2, 16'h0000, 2'b11);

    // random mix
    for (int n = 0; n < 400; n++) begin
      doAccess(1'($urandom % 2), int'($urandom % 16), 16'($urandom),
               2'($urandom % 4));
    end
    for (int k = 0; k < 16; k++) doAccess(1'b0, k, 16'h0000, 2'b11);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule